// File: doc/BRIEF.md
# SDRAM Read Data Path with Burst Stop

This block models the device side of the read data path in a single-data-rate synchronous DRAM with one bank. Each clock it receives decoded command strobes (open bank, read, burst stop, close bank) and drives a read data bus with an output-enable flag. A read schedules four beats, one per clock. Each beat reaches the pins a selectable CAS latency of two or three clocks after it was scheduled.

A burst stop or a bank close that arrives while a burst is running cancels every beat not yet scheduled. The output therefore goes quiet exactly one CAS latency after that command. A burst stop keeps the bank open, so a fresh read may follow at once. A bank close shuts the bank. The read data is a fixed function of the column address and the beat index, so every beat can be checked. Commands that cannot be honoured raise a one-cycle error pulse and are dropped.

Top module: `sdr_read_term_path`

## Requirements
- R1: While reset is high and in the first cycle after it, rd_oe, rd_data, bank_open and cmd_err are all zero.
- R2: An act_req strobe alone sets bank_open in the following cycle. An act_req while the bank is already open is accepted without error.
- R3: A read_req alone with the bank open gives four consecutive cycles of rd_oe high. The first of these comes CL clocks after the read, where CL is 2 when cl_sel is 0 and 3 when cl_sel is 1.
- R4: Beat i of a read (i = 0..3) carries the value (col_addr + i) modulo 2^COL_W, zero-extended to DATA_W bits.
- R5: A tbst_req issued k cycles after a read (k = 1, 2 or 3) lets exactly k beats out, and rd_oe falls CL cycles after the tbst_req.
- R6: After a burst stop bank_open stays high, and a read issued in the very next cycle is served in full.
- R7: A pre_req during a burst truncates output exactly like a burst stop, and bank_open is low from the next cycle.
- R8: A read_req, tbst_req or pre_req while the bank is closed makes cmd_err high for one cycle in the next cycle and produces no output.
- R9: More than one strobe in the same cycle, such as a read together with a burst stop, makes cmd_err high in the next cycle, and every command of that cycle is ignored.
- R10: A read issued during a running burst replaces the old burst's remaining beats, starting at the new read's own CL point. Beats of the old burst that were due earlier still appear.
- R11: Whenever rd_oe is low, rd_data is all zeros.
- R12: A tbst_req with the bank open and no burst running changes nothing at the outputs and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cl_sel | input | 1 | CAS latency select: 0 gives 2 clocks, 1 gives 3 clocks |
| read_req | input | 1 | Read command strobe |
| tbst_req | input | 1 | Burst stop command strobe |
| pre_req | input | 1 | Bank close command strobe |
| act_req | input | 1 | Bank open command strobe |
| col_addr | input | COL_W | Column address for a read |
| rd_data | output | DATA_W | Read data, zero when not enabled |
| rd_oe | output | 1 | High in cycles that carry a valid beat |
| bank_open | output | 1 | Bank is open |
| cmd_err | output | 1 | One-cycle pulse after an illegal command |

## Verification
A burst counter that is wrong shows up at the pins CL cycles later, as a missing, extra or repeated beat value. A cancel that fails to clear the issue stage leaves rd_oe high beyond the expected last beat. A pipeline tap on the wrong stage moves the whole burst by one cycle, so the first compared cycle already fails. Bank-state errors appear one cycle after the command, either as a spurious cmd_err pulse or as a read that produces nothing.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_READ,
    OP_TBST,
    OP_PRE,
    OP_ACT,
    OP_BAD
  } op_e;

  // One strobe at most per cycle; anything else is a clash.
  function automatic op_e decode_op(input logic rd, input logic tb,
                                    input logic pr, input logic ac);
    op_e op;
    unique case ({rd, tb, pr, ac})
      4'b0000: op = OP_NOP;
      4'b1000: op = OP_READ;
      4'b0100: op = OP_TBST;
      4'b0010: op = OP_PRE;
      4'b0001: op = OP_ACT;
      default: op = OP_BAD;
    endcase
    return op;
  endfunction

  function automatic logic op_needs_bank(input op_e op);
    return (op == OP_READ) || (op == OP_TBST) || (op == OP_PRE);
  endfunction

endpackage

// File: rtl/sdr_cmd_ctrl.sv
module sdr_cmd_ctrl
  import sdr_rd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic read_req,
  input  logic tbst_req,
  input  logic pre_req,
  input  logic act_req,
  output logic go_read,
  output logic go_stop,
  output logic bank_open,
  output logic cmd_err
);

  op_e  op;
  logic clash;
  logic closed_use;
  logic go_pre;
  logic go_tbst;

  always_comb begin
    op         = decode_op(read_req, tbst_req, pre_req, act_req);
    clash      = (op == OP_BAD);
    closed_use = op_needs_bank(op) && !bank_open;
    go_read    = (op == OP_READ) && bank_open;
    go_tbst    = (op == OP_TBST) && bank_open;
    go_pre     = (op == OP_PRE)  && bank_open;
    go_stop    = go_tbst || go_pre;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_open <= 1'b0;
      cmd_err   <= 1'b0;
    end else begin
      cmd_err <= clash || closed_use;
      if (op == OP_ACT)
        bank_open <= 1'b1;
      else if (go_pre)
        bank_open <= 1'b0;
    end
  end

  // R9
  clash_err_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones({read_req, tbst_req, pre_req, act_req}) > 1) |=> cmd_err);

  // R8
  closed_err_chk: assert property (@(posedge clk) disable iff (rst)
    (!bank_open && !act_req && (read_req || tbst_req || pre_req)) |=> cmd_err);

  // R6
  tbst_keeps_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (bank_open && tbst_req && !read_req && !pre_req && !act_req) |=> bank_open);

  // R7
  pre_closes_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_req && !read_req && !tbst_req && !act_req) |=> !bank_open);

  // R2
  act_opens_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (act_req && !read_req && !tbst_req && !pre_req) |=> (bank_open && !cmd_err));

endmodule

// File: rtl/sdr_burst_gen.sv
module sdr_burst_gen #(
  parameter int COL_W     = 9,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_read,
  input  logic             go_stop,
  input  logic [COL_W-1:0] col_addr,
  output logic             iss_valid,
  output logic [COL_W-1:0] iss_col
);

  localparam int CNT_W = (BURST_LEN > 2) ? $clog2(BURST_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN - 1);

  logic             run;
  logic [CNT_W-1:0] cnt;
  logic [COL_W-1:0] base;

  // Column of a beat: base plus offset, wrapping within the column space.
  function automatic logic [COL_W-1:0] beat_col(input logic [COL_W-1:0] b,
                                                input logic [CNT_W-1:0] off);
    return COL_W'(b + COL_W'(off));
  endfunction

  always_comb begin
    iss_valid = 1'b0;
    iss_col   = '0;
    if (go_read) begin
      iss_valid = 1'b1;
      iss_col   = col_addr;
    end else if (!go_stop && run) begin
      iss_valid = 1'b1;
      iss_col   = beat_col(base, cnt);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      cnt  <= '0;
      base <= '0;
    end else if (go_read) begin
      run  <= 1'b1;
      cnt  <= CNT_W'(1);
      base <= col_addr;
    end else if (go_stop) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + CNT_W'(1);
      if (cnt == LAST)
        run <= 1'b0;
    end
  end

  // R5
  stop_ends_burst_chk: assert property (@(posedge clk) disable iff (rst)
    (go_stop && !go_read) |=> !iss_valid || go_read);

  // R3
  count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt != '0));

  // R10
  restart_beat0_chk: assert property (@(posedge clk) disable iff (rst)
    go_read |-> (iss_valid && iss_col == col_addr));

endmodule

// File: rtl/sdr_lat_pipe.sv
module sdr_lat_pipe #(
  parameter int COL_W  = 9,
  parameter int DATA_W = 16,
  parameter int CL_MIN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cl_sel,
  input  logic              iss_valid,
  input  logic [COL_W-1:0]  iss_col,
  output logic              rd_oe,
  output logic [DATA_W-1:0] rd_data
);

  localparam int CL_MAX = CL_MIN + 1;

  logic [CL_MAX-1:0] vld;
  logic [COL_W-1:0]  col [CL_MAX];
  logic              tap_vld;
  logic [COL_W-1:0]  tap_col;

  function automatic logic [DATA_W-1:0] widen(input logic [COL_W-1:0] c);
    return DATA_W'(c);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      for (int s = 0; s < CL_MAX; s++) col[s] <= '0;
    end else begin
      vld[0] <= iss_valid;
      col[0] <= iss_valid ? iss_col : '0;
      for (int s = 1; s < CL_MAX; s++) begin
        vld[s] <= vld[s-1];
        col[s] <= col[s-1];
      end
    end
  end

  always_comb begin
    tap_vld = cl_sel ? vld[CL_MAX-1] : vld[CL_MIN-1];
    tap_col = cl_sel ? col[CL_MAX-1] : col[CL_MIN-1];
    rd_oe   = tap_vld;
    rd_data = tap_vld ? widen(tap_col) : '0;
  end

  // R11
  quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_oe |-> (rd_data == '0));

  // R3
  issue_enters_chk: assert property (@(posedge clk) disable iff (rst)
    iss_valid |=> vld[0]);

endmodule

// File: rtl/sdr_read_term_path.sv
module sdr_read_term_path #(
  parameter int COL_W     = 9,
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 4,
  parameter int CL_MIN    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cl_sel,
  input  logic              read_req,
  input  logic              tbst_req,
  input  logic              pre_req,
  input  logic              act_req,
  input  logic [COL_W-1:0]  col_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe,
  output logic              bank_open,
  output logic              cmd_err
);

  logic             go_read;
  logic             go_stop;
  logic             iss_valid;
  logic [COL_W-1:0] iss_col;

  sdr_cmd_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .read_req  (read_req),
    .tbst_req  (tbst_req),
    .pre_req   (pre_req),
    .act_req   (act_req),
    .go_read   (go_read),
    .go_stop   (go_stop),
    .bank_open (bank_open),
    .cmd_err   (cmd_err)
  );

  sdr_burst_gen #(.COL_W(COL_W), .BURST_LEN(BURST_LEN)) u_burst (
    .clk       (clk),
    .rst       (rst),
    .go_read   (go_read),
    .go_stop   (go_stop),
    .col_addr  (col_addr),
    .iss_valid (iss_valid),
    .iss_col   (iss_col)
  );

  sdr_lat_pipe #(.COL_W(COL_W), .DATA_W(DATA_W), .CL_MIN(CL_MIN)) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .cl_sel    (cl_sel),
    .iss_valid (iss_valid),
    .iss_col   (iss_col),
    .rd_oe     (rd_oe),
    .rd_data   (rd_data)
  );

  // R8
  no_issue_closed_chk: assert property (@(posedge clk) disable iff (rst)
    !bank_open |-> !go_read);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    $past(rst) |-> (!cmd_err && !bank_open));

endmodule

// File: tb/test_sdr_read_term_path.sv
module test_sdr_read_term_path;

  localparam int COL_W  = 9;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cl_sel = 1'b0;
  logic              read_req = 1'b0;
  logic              tbst_req = 1'b0;
  logic              pre_req = 1'b0;
  logic              act_req = 1'b0;
  logic [COL_W-1:0]  col_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              rd_oe;
  logic              bank_open;
  logic              cmd_err;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    mon_on = 1'b0;
  bit    bank_m = 1'b0;
  string ctx = "R3 R11";

  logic [DATA_W-1:0] exp_beat [int];
  bit                exp_err  [int];

  sdr_read_term_path i_sdr_read_term_path (
    .clk(clk), .rst(rst), .cl_sel(cl_sel), .read_req(read_req),
    .tbst_req(tbst_req), .pre_req(pre_req), .act_req(act_req),
    .col_addr(col_addr), .rd_data(rd_data), .rd_oe(rd_oe),
    .bank_open(bank_open), .cmd_err(cmd_err)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic int cl_now();
    return cl_sel ? 3 : 2;
  endfunction

  // Scoreboard monitor: every cycle compares the bus and error flag.
  always @(negedge clk) begin
    if (mon_on) begin
      if (exp_beat.exists(cyc))
        chk(rd_oe && rd_data == exp_beat[cyc], ctx, {rd_oe, rd_data}, {1'b1, exp_beat[cyc]});
      else
        chk(!rd_oe && rd_data == '0, ctx, {rd_oe, rd_data}, 0);
      chk(cmd_err == exp_err.exists(cyc), "R8 or R9 error flag", cmd_err, exp_err.exists(cyc));
    end
  end

  task automatic drop_from(input int first);
    for (int k = first; k < first + 8; k++)
      if (exp_beat.exists(k)) exp_beat.delete(k);
  endtask

  // Driver: presents one cycle of strobes and pushes what must follow.
  task automatic send(input bit rd, input bit tb, input bit pr, input bit ac,
                      input logic [COL_W-1:0] a);
    int c;
    int n;
    @(negedge clk);
    read_req = rd; tbst_req = tb; pre_req = pr; act_req = ac; col_addr = a;
    c = cyc;
    n = rd + tb + pr + ac;
    if (n > 1) exp_err[c+1] = 1'b1;
    else if (!bank_m && (rd || tb || pr)) exp_err[c+1] = 1'b1;
    else if (ac) bank_m = 1'b1;
    else if (rd) begin
      drop_from(c + cl_now());
      for (int i = 0; i < 4; i++)
        exp_beat[c + cl_now() + i] = DATA_W'(COL_W'(a + COL_W'(i)));
    end else if (tb || pr) begin
      drop_from(c + cl_now());
      if (pr) bank_m = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      read_req = 0; tbst_req = 0; pre_req = 0; act_req = 0;
    end
  endtask

  task automatic chk_bank(input bit e, input string req);
    chk(bank_open == e, req, bank_open, e);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rd_oe && rd_data == '0 && !bank_open && !cmd_err, "R1 in reset",
        {rd_oe, bank_open, cmd_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rd_oe && rd_data == '0 && !bank_open && !cmd_err, "R1 after reset",
        {rd_oe, bank_open, cmd_err}, 0);
    mon_on = 1'b1;

    ctx = "R8 closed read";
    send(1, 0, 0, 0, 9'h020); idle(6);
    send(0, 1, 0, 0, 0); idle(2);

    send(0, 0, 0, 1, 0); idle(1);
    chk_bank(1, "R2 open");
    send(0, 0, 0, 1, 0); idle(1);
    chk_bank(1, "R2 reopen");

    ctx = "R3 R4 R11 CL2 full burst";
    cl_sel = 0;
    send(1, 0, 0, 0, 9'h010); idle(8);
    ctx = "R3 R4 CL3 wrapping burst";
    cl_sel = 1;
    send(1, 0, 0, 0, 9'h1FE); idle(8);

    for (int cl = 0; cl < 2; cl++) begin
      cl_sel = cl[0];
      for (int k = 1; k <= 3; k++) begin
        ctx = "R5 burst stop";
        send(1, 0, 0, 0, 9'(9'h040 + k * 16));
        idle(k - 1);
        send(0, 1, 0, 0, 0);
        idle(1);
        chk_bank(1, "R6 bank kept");
        idle(7);
      end
    end

    ctx = "R6 read right after stop";
    cl_sel = 0;
    send(1, 0, 0, 0, 9'h0A0);
    send(0, 1, 0, 0, 0);
    send(1, 0, 0, 0, 9'h0B0); idle(8);

    ctx = "R12 idle stop";
    send(0, 1, 0, 0, 0); idle(5);

    ctx = "R10 read over read";
    cl_sel = 1;
    send(1, 0, 0, 0, 9'h100); idle(1);
    send(1, 0, 0, 0, 9'h180); idle(9);

    ctx = "R9 clash";
    send(1, 1, 0, 0, 9'h033); idle(6);
    send(1, 0, 0, 1, 9'h044); idle(6);
    chk_bank(1, "R9 bank unchanged");

    ctx = "R7 close truncates";
    cl_sel = 0;
    send(1, 0, 0, 0, 9'h0C0); idle(1);
    send(0, 0, 1, 0, 0); idle(1);
    chk_bank(0, "R7 closed");
    idle(6);
    ctx = "R8 stop while closed";
    send(0, 1, 0, 0, 0); idle(3);
    send(0, 0, 1, 0, 0); idle(3);

    mon_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule